// File: doc/BRIEF.md
# Voice Group Playlist Sequencer

This block plays one voice group by stepping through a list of memory-block numbers. Each group is a run of entries in one shared entry pool. A run can repeat a block, list blocks in any order, and share entries with other groups. A small index table gives each group a first-entry pointer and an entry count. A start pulse with a group number loads that group. The sequencer then reads the pool one entry at a time and offers each block number to a downstream audio fetch engine. It moves to the next entry only after that engine reports the block finished. A group-done pulse marks the end of the list.

The block-number request is a valid/ready stream. While `req_valid` is high and `req_ready` is low, the offered block number is held steady. The transfer takes place on a clock edge where both are high. After a transfer, no new request is offered until `blk_done` is seen. Start, retrigger enable, abort, busy and group-done are plain level or pulse pins. Both tables are loaded through simple write ports before playback.

Top module: `voice_playlist_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and `group_done` are all low.
- R2: In the cycle after a start pulse with an in-range group whose count is non-zero, `busy` is high. In that same cycle `req_valid` is high and `req_blk` equals the pool entry at the group's start pointer.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_blk` stays unchanged. In the cycle after a transfer, `req_valid` is low.
- R4: The request for the next entry appears in the cycle after `blk_done` is high. A `blk_done` while a request is still waiting to be accepted has no effect. With no `blk_done`, no new request is offered.
- R5: Blocks are requested in list order, one request per entry, as 8-bit block numbers. Repeated entries and descending or non-contiguous block numbers are passed on unchanged.
- R6: In the cycle after `blk_done` for the last entry, `busy` is low and `group_done` is high for exactly one cycle.
- R7: A start of a group with entry count 0 gives `group_done` high in the next cycle. It issues no request and `busy` stays low.
- R8: In the cycle after `abort` is high, `busy` and `req_valid` are low, and the interrupted group never pulses `group_done`. `abort` wins over a `start` in the same cycle.
- R9: A start while `busy` is high and `retrig_en` is low is ignored, and the current group plays on to its end.
- R10: A start while `busy` is high and `retrig_en` is high restarts playback from the first entry of the newly given group. The offered block changes in the next cycle.
- R11: A start whose group number is not below NUM_GROUPS (30 by default) is ignored.
- R12: Index-table rows 0 to NUM_GROUPS-1 and pool addresses 0 to POOL_DEPTH-1 (896 by default) are writable and used by later starts. This includes the last row and the last pool entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Index-table write strobe |
| tbl_wr_grp | input | GRP_W (5) | Index-table row to write |
| tbl_wr_start | input | PTR_W (10) | First-entry pointer for the row |
| tbl_wr_count | input | CNT_W (10) | Entry count for the row |
| pool_wr_en | input | 1 | Entry-pool write strobe |
| pool_wr_addr | input | PTR_W (10) | Pool address to write |
| pool_wr_blk | input | BLK_W (8) | Block number stored at that address |
| start | input | 1 | Start pulse |
| grp | input | GRP_W (5) | Group number sampled with start |
| retrig_en | input | 1 | Allows a start while busy to restart playback |
| abort | input | 1 | Stops playback at once |
| req_valid | output | 1 | Block request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_blk | output | BLK_W (8) | Requested memory-block number |
| blk_done | input | 1 | Downstream finished the accepted block |
| busy | output | 1 | A group is playing |
| group_done | output | 1 | One-cycle pulse at the end of a group |

## Verification
The assertions assume that both write ports only use in-range row numbers and pool addresses. They also assume that every table row in use points at entries inside the pool. The downstream engine is assumed to raise `blk_done` only for a block it has accepted. The bench writes each table row and pool entry once, during the initial load. It plays each block only after taking the request, and it sends stray `blk_done` pulses only while a request is still waiting. That stray pulse is there to test that it is ignored.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_OFFER = 2'd1,
    SQ_PLAY  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/vps_index_table.sv
module vps_index_table #(
  parameter int NUM_GROUPS = 30,
  parameter int GRP_W      = 5,
  parameter int PTR_W      = 10,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_grp,
  input  logic [PTR_W-1:0] wr_start,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [GRP_W-1:0] rd_grp,
  output logic [PTR_W-1:0] rd_start,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_ok
);
  logic [PTR_W-1:0] start_row [NUM_GROUPS];
  logic [CNT_W-1:0] count_row [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && (wr_grp == GRP_W'(g))) begin
        start_row[g] <= wr_start;
        count_row[g] <= wr_count;
      end
    end
  end

  always_comb begin
    rd_ok    = (int'(rd_grp) < NUM_GROUPS);
    rd_start = '0;
    rd_count = '0;
    if (rd_ok) begin
      rd_start = start_row[rd_grp];
      rd_count = count_row[rd_grp];
    end
  end

  // R12: rows written must exist
  p_tbl_row_range_r12: assert property (@(posedge clk)
    wr_en |-> (int'(wr_grp) < NUM_GROUPS));
endmodule

// File: rtl/vps_entry_pool.sv
module vps_entry_pool #(
  parameter int POOL_DEPTH = 896,
  parameter int PTR_W      = 10,
  parameter int BLK_W      = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [BLK_W-1:0] rd_blk
);
  logic [BLK_W-1:0] mem [POOL_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < POOL_DEPTH)) mem[wr_addr] <= wr_blk;
  end

  assign rd_blk = (int'(rd_addr) < POOL_DEPTH) ? mem[rd_addr] : '0;

  // R12: pool writes stay inside the pool
  p_pool_addr_range_r12: assert property (@(posedge clk)
    wr_en |-> (int'(wr_addr) < POOL_DEPTH));
endmodule

// File: rtl/vps_seq_ctrl.sv
module vps_seq_ctrl
  import vps_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             grp_ok,
  input  logic             retrig_en,
  input  logic             abort,
  input  logic [PTR_W-1:0] grp_start,
  input  logic [CNT_W-1:0] grp_count,
  input  logic             req_ready,
  input  logic             blk_done,
  output logic [PTR_W-1:0] entry_ptr,
  output logic             req_valid,
  output logic             busy,
  output logic             group_done
);
  sq_state_t        state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] left_q;
  logic             done_q;
  logic             accept;

  assign accept = start && grp_ok && ((state_q == SQ_IDLE) || retrig_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        state_q <= SQ_IDLE;
      end else if (accept) begin
        if (grp_count == '0) begin
          state_q <= SQ_IDLE;
          done_q  <= 1'b1;
        end else begin
          state_q <= SQ_OFFER;
          ptr_q   <= grp_start;
          left_q  <= grp_count;
        end
      end else begin
        case (state_q)
          SQ_OFFER: if (req_ready) state_q <= SQ_PLAY;
          SQ_PLAY: begin
            if (blk_done) begin
              if (left_q == CNT_W'(1)) begin
                state_q <= SQ_IDLE;
                done_q  <= 1'b1;
              end else begin
                ptr_q   <= ptr_q + PTR_W'(1);
                left_q  <= left_q - CNT_W'(1);
                state_q <= SQ_OFFER;
              end
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign entry_ptr  = ptr_q;
  assign req_valid  = (state_q == SQ_OFFER);
  assign busy       = (state_q != SQ_IDLE);
  assign group_done = done_q;

  // R3: a waiting request keeps its pointer until taken
  p_hold_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort && !accept) |=> (req_valid && $stable(ptr_q)));
  // R3: a taken request is not offered again
  p_taken_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !abort && !accept) |=> !req_valid);
  // R4: no new request while a block is playing without completion
  p_wait_for_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SQ_PLAY) && !blk_done && !abort && !accept) |=> !req_valid);
  // R7: empty group completes at once
  p_empty_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (grp_count == '0) && !abort) |=> (group_done && !busy && !req_valid));
  // R8: abort silences everything
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !req_valid && !group_done));
  // R9: an ignored start does not end the group early
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !retrig_en && !abort) |=> (busy || group_done));
endmodule

// File: rtl/voice_playlist_seq.sv
module voice_playlist_seq #(
  parameter int NUM_GROUPS = 30,
  parameter int POOL_DEPTH = 896,
  parameter int BLK_W      = 8,
  localparam int GRP_W     = $clog2(NUM_GROUPS + 1),
  localparam int PTR_W     = $clog2(POOL_DEPTH),
  localparam int CNT_W     = $clog2(POOL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr_en,
  input  logic [GRP_W-1:0] tbl_wr_grp,
  input  logic [PTR_W-1:0] tbl_wr_start,
  input  logic [CNT_W-1:0] tbl_wr_count,
  input  logic             pool_wr_en,
  input  logic [PTR_W-1:0] pool_wr_addr,
  input  logic [BLK_W-1:0] pool_wr_blk,
  input  logic             start,
  input  logic [GRP_W-1:0] grp,
  input  logic             retrig_en,
  input  logic             abort,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [BLK_W-1:0] req_blk,
  input  logic             blk_done,
  output logic             busy,
  output logic             group_done
);
  logic [PTR_W-1:0] sel_start;
  logic [CNT_W-1:0] sel_count;
  logic             sel_ok;
  logic [PTR_W-1:0] entry_ptr;

  vps_index_table #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_index (
    .clk(clk), .wr_en(tbl_wr_en), .wr_grp(tbl_wr_grp),
    .wr_start(tbl_wr_start), .wr_count(tbl_wr_count),
    .rd_grp(grp), .rd_start(sel_start), .rd_count(sel_count), .rd_ok(sel_ok)
  );

  vps_entry_pool #(
    .POOL_DEPTH(POOL_DEPTH), .PTR_W(PTR_W), .BLK_W(BLK_W)
  ) u_pool (
    .clk(clk), .wr_en(pool_wr_en), .wr_addr(pool_wr_addr), .wr_blk(pool_wr_blk),
    .rd_addr(entry_ptr), .rd_blk(req_blk)
  );

  vps_seq_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_ok(sel_ok),
    .retrig_en(retrig_en), .abort(abort),
    .grp_start(sel_start), .grp_count(sel_count),
    .req_ready(req_ready), .blk_done(blk_done),
    .entry_ptr(entry_ptr), .req_valid(req_valid),
    .busy(busy), .group_done(group_done)
  );

  // R6: completion is never reported with a request on offer
  p_done_without_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |-> !req_valid);
  // R11: out-of-range start from idle leaves the block idle
  p_bad_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel_ok && !busy) |=> (!busy && !group_done));
endmodule

// File: tb/sim_voice_playlist_seq.sv
module sim_voice_playlist_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 5, PW = 10, CW = 10, BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_wr_en = 0, pool_wr_en = 0, start = 0, retrig_en = 0, abort = 0;
  logic req_ready = 0, blk_done = 0;
  logic [GW-1:0] tbl_wr_grp = '0, grp = '0;
  logic [PW-1:0] tbl_wr_start = '0, pool_wr_addr = '0;
  logic [CW-1:0] tbl_wr_count = '0;
  logic [BW-1:0] pool_wr_blk = '0;
  logic req_valid, busy, group_done;
  logic [BW-1:0] req_blk;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_playlist_seq u0 (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_grp(tbl_wr_grp),
    .tbl_wr_start(tbl_wr_start), .tbl_wr_count(tbl_wr_count),
    .pool_wr_en(pool_wr_en), .pool_wr_addr(pool_wr_addr), .pool_wr_blk(pool_wr_blk),
    .start(start), .grp(grp), .retrig_en(retrig_en), .abort(abort),
    .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk),
    .blk_done(blk_done), .busy(busy), .group_done(group_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_grp(input int g, input int s, input int c);
    tbl_wr_en = 1; tbl_wr_grp = GW'(g); tbl_wr_start = PW'(s); tbl_wr_count = CW'(c);
    step(); tbl_wr_en = 0;
  endtask

  task automatic load_pool(input int a, input int b);
    pool_wr_en = 1; pool_wr_addr = PW'(a); pool_wr_blk = BW'(b);
    step(); pool_wr_en = 0;
  endtask

  task automatic kick(input int g, input bit rt);
    start = 1; grp = GW'(g); retrig_en = rt;
    step(); start = 0; retrig_en = 0;
  endtask

  // take one request, check its block number, then report it played
  task automatic serve(input int exp, input string tag);
    int waited = 0;
    while (!req_valid && waited < 20) begin step(); waited++; end
    check(req_valid && req_blk == BW'(exp), tag, int'(req_blk), exp);
    req_ready = 1; step(); req_ready = 0;
    check(!req_valid, "R3 request dropped after transfer", int'(req_valid), 0);
    blk_done = 1; step(); blk_done = 0;
  endtask

  task automatic expect_end(input string tag);
    check(group_done && !busy, tag, int'({group_done, busy}), 2);
    step();
    check(!group_done, "R6 done lasts one cycle", int'(group_done), 0);
  endtask

  task automatic t_reset();
    check(!busy && !req_valid && !group_done, "R1 reset state",
          int'({busy, req_valid, group_done}), 0);
  endtask

  task automatic t_basic();
    kick(0, 0);
    check(busy && req_valid && req_blk == 8'd5, "R2 first request after start",
          int'(req_blk), 5);
    serve(5, "R5 basic entry 0");
    serve(9, "R5 basic entry 1");
    serve(2, "R5 basic entry 2");
    expect_end("R6 end of basic group");
  endtask

  task automatic t_repeat();
    kick(1, 0);
    serve(7, "R5 repeat 0"); serve(7, "R5 repeat 1");
    serve(7, "R5 repeat 2"); serve(250, "R5 repeat 3");
    expect_end("R6 end of repeat group");
  endtask

  task automatic t_backpressure();
    kick(2, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      check(req_valid && req_blk == 8'd253, "R3 held under back-pressure", int'(req_blk), 253);
    end
    blk_done = 1; step(); blk_done = 0;
    check(req_valid && req_blk == 8'd253, "R4 stray done while offered", int'(req_blk), 253);
    req_ready = 1; step(); req_ready = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(!req_valid && busy, "R4 no request before done", int'(req_valid), 0);
    end
    blk_done = 1; step(); blk_done = 0;
    check(req_valid && req_blk == 8'd100, "R4 next request after done", int'(req_blk), 100);
    serve(100, "R5 descending 1");
    serve(1, "R5 descending 2");
    expect_end("R6 end of descending group");
  endtask

  task automatic t_empty();
    kick(3, 0);
    check(group_done && !busy && !req_valid, "R7 empty group done",
          int'({group_done, busy, req_valid}), 4);
    step();
    check(!group_done && !req_valid, "R7 no request after empty", int'(req_valid), 0);
  endtask

  task automatic t_abort();
    bit saw_done = 0;
    kick(0, 0);
    serve(5, "R8 pre-abort block");
    req_ready = 1; step(); req_ready = 0;
    abort = 1; step(); abort = 0;
    check(!busy && !req_valid, "R8 abort clears", int'({busy, req_valid}), 0);
    for (int i = 0; i < 6; i++) begin
      if (group_done) saw_done = 1;
      step();
    end
    check(!saw_done, "R8 no done after abort", int'(saw_done), 0);
    start = 1; grp = 5'd0; abort = 1; step(); start = 0; abort = 0;
    check(!busy && !req_valid, "R8 abort beats start", int'(busy), 0);
  endtask

  task automatic t_ignore();
    kick(0, 0);
    kick(2, 0);
    check(req_valid && req_blk == 8'd5, "R9 busy start ignored", int'(req_blk), 5);
    serve(5, "R9 play on 0"); serve(9, "R9 play on 1"); serve(2, "R9 play on 2");
    expect_end("R9 original group ends");
  endtask

  task automatic t_retrig();
    kick(0, 0);
    serve(5, "R10 before retrigger");
    kick(2, 1);
    check(req_valid && req_blk == 8'd253, "R10 restart at new group", int'(req_blk), 253);
    serve(253, "R10 after 0"); serve(100, "R10 after 1"); serve(1, "R10 after 2");
    expect_end("R10 restarted group ends");
  endtask

  task automatic t_range_and_top();
    kick(31, 0);
    check(!busy && !req_valid && !group_done, "R11 out-of-range group", int'(busy), 0);
    kick(30, 0);
    check(!busy && !req_valid, "R11 group equal to count", int'(busy), 0);
    kick(29, 0);
    serve(171, "R12 last row and last pool entry");
    expect_end("R12 last row ends");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    load_pool(0, 5); load_pool(1, 9); load_pool(2, 2);
    load_pool(3, 7); load_pool(4, 7); load_pool(5, 7); load_pool(6, 250);
    load_pool(7, 253); load_pool(8, 100); load_pool(9, 1);
    load_pool(895, 171);
    load_grp(0, 0, 3); load_grp(1, 3, 4); load_grp(2, 7, 3);
    load_grp(3, 0, 0); load_grp(29, 895, 1);
    t_reset();
    t_basic(); step();
    t_repeat(); step();
    t_backpressure(); step();
    t_empty(); step();
    t_abort(); step();
    t_ignore(); step();
    t_retrig(); step();
    t_range_and_top(); step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule